// File: doc/BRIEF.md
# Mode-switched shared microcode RAM

This block is a 2048-word by 32-bit static RAM (8 Kbytes) with three ways in. A host data-bus port reaches it as general-purpose memory. Two engine ports, A and B, read it as a control store. Each engine signals through its own emulation input that it has taken the array. While either of these inputs is high, the host is locked out of the array. Each emulating engine can read over its own port with one cycle of latency, and neither engine ever stalls the other.

The host also reaches a small register window. This window holds a STOP bit for low-power entry, a base-address register that must be programmed before array addresses decode, and a signature unit. The signature unit sweeps the whole array and folds every word into a 32-bit shift-register value. Software compares that value against one it computed itself to detect corrupted contents.

Host responses arrive one cycle after a request. Each response is either an acknowledge or an error. Rejected writes leave the array unchanged.

Top module: `ucs_ram`

## Requirements
- R1: With the base register at 0xFFA0, no emulation and no low-power state, a host data access whose word address bits [21:11] equal 0x7FD reaches array word [10:0]. A write is stored. A read returns the stored word on `hst_rdata`. `hst_ack` is high, and `hst_err` is low, in the cycle after the request.
- R2: A host array access (`hst_reg`=0) is answered with `hst_err`=1 and read data 0 when the base register is not 0xFFA0 or when address bits [21:11] are not 0x7FD. Write data is discarded.
- R3: While `emu_a` or `emu_b` is high, every host array access is answered with `hst_err`=1 and leaves the array unchanged.
- R4: An engine port whose emulation input is high returns the addressed word one cycle after its read strobe. Both ports can read in the same cycle. A read strobe on a port whose emulation input is low returns 0.
- R5: Writing 1 to bit 0 of control register 0 (STOP) raises `low_power` when no engine is emulating. While `low_power` is high, host array accesses get `hst_err`, but register accesses still work.
- R6: While `emu_a` or `emu_b` is high, `low_power` stays low even when STOP is set. It rises again once both emulation inputs drop.
- R7: A host request with `hst_fetch`=1 (instruction fetch) is answered with `hst_err`=1 whatever its target, and it changes nothing.
- R8: Writing 1 to bit 0 of register 3 starts a scan. The scan starts from seed 0xFFFFFFFF and visits words 0 to 2047 in order, one per cycle. For each word w it sets sig = ({sig[30:0],0} xor (sig[31] ? 0x04C11DB7 : 0)) xor w. After the last word, done (register 3 bit 0) is set and busy (bit 1) is cleared. Register 2 returns sig.
- R9: Register selection uses `hst_addr[1:0]` with `hst_reg`=1. Register 0 holds STOP in bit 0 and reads `low_power` in bit 1. Register 1 holds the base in bits [15:0]. Registers 0, 1 and 3 read 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hst_req | input | 1 | Host request strobe, one cycle |
| hst_reg | input | 1 | 1 = register window, 0 = array |
| hst_we | input | 1 | 1 = write |
| hst_fetch | input | 1 | 1 = instruction fetch (always rejected) |
| hst_addr | input | 22 | Host word address |
| hst_wdata | input | 32 | Host write data |
| hst_ack | output | 1 | Access accepted, one cycle after request |
| hst_err | output | 1 | Access rejected, one cycle after request |
| hst_rdata | output | 32 | Read data, valid with hst_ack |
| emu_a | input | 1 | Engine A emulation mode |
| emu_b | input | 1 | Engine B emulation mode |
| eng_a_rd | input | 1 | Engine A read strobe |
| eng_a_addr | input | 11 | Engine A word address |
| eng_a_rdata | output | 32 | Engine A read data |
| eng_b_rd | input | 1 | Engine B read strobe |
| eng_b_addr | input | 11 | Engine B word address |
| eng_b_rdata | output | 32 | Engine B read data |
| low_power | output | 1 | Block is in the low-power state |

## Verification
Three things can happen in the same cycle during emulation: both engine ports read, and the host attempts an array access. The bench provokes this with a random run that strobes both engine reads and a host read or write in one cycle. Both engine words are judged against a bench memory model. The host attempt must yield an error, and a later read-back after emulation ends must show the word unchanged. A second overlap is STOP set while an engine is emulating: the bench checks that `low_power` stays low and returns once emulation ends.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  localparam logic [31:0] SIG_POLY = 32'h04C11DB7;
  localparam logic [31:0] SIG_SEED = 32'hFFFFFFFF;
  localparam logic [1:0]  REG_CTRL = 2'd0;
  localparam logic [1:0]  REG_BASE = 2'd1;
  localparam logic [1:0]  REG_SIG  = 2'd2;
  localparam logic [1:0]  REG_STAT = 2'd3;

  function automatic logic [31:0] sig_fold(input logic [31:0] acc, input logic [31:0] word);
    logic [31:0] sh;
    sh = {acc[30:0], 1'b0} ^ (acc[31] ? SIG_POLY : 32'h0);
    return sh ^ word;
  endfunction
endpackage

// File: rtl/ucs_array.sv
module ucs_array #(
  parameter int WORDS = 2048,
  parameter int DW    = 32,
  localparam int AW   = $clog2(WORDS),
  localparam int NENG = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_we,
  input  logic          h_re,
  input  logic [AW-1:0] h_addr,
  input  logic [DW-1:0] h_wdata,
  output logic [DW-1:0] h_rdata,
  input  logic [NENG-1:0] e_rd,
  input  logic [NENG-1:0] e_en,
  input  logic [AW-1:0] e_addr [NENG],
  output logic [DW-1:0] e_rdata [NENG],
  input  logic [AW-1:0] s_addr,
  output logic [DW-1:0] s_word
);
  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] h_rdata_q, h_rdata_d;

  always_ff @(posedge clk) begin
    if (h_we) mem[h_addr] <= h_wdata;
  end

  always_comb h_rdata_d = h_re ? mem[h_addr] : h_rdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) h_rdata_q <= '0;
    else        h_rdata_q <= h_rdata_d;
  end

  assign h_rdata = h_rdata_q;
  assign s_word  = mem[s_addr];

  for (genvar g = 0; g < NENG; g++) begin : g_eng
    logic [DW-1:0] rd_q, rd_d;
    always_comb begin
      rd_d = rd_q;
      if (e_rd[g]) rd_d = e_en[g] ? mem[e_addr[g]] : '0;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_q <= '0;
      else        rd_q <= rd_d;
    end
    assign e_rdata[g] = rd_q;

    // R4: an engine not in emulation reads zero
    p_idle_engine_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (e_rd[g] && !e_en[g]) |=> (e_rdata[g] == '0));
  end
endmodule

// File: rtl/ucs_sig.sv
module ucs_sig #(
  parameter int WORDS = 2048,
  localparam int AW   = $clog2(WORDS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [31:0]   word,
  output logic [AW-1:0] addr,
  output logic [31:0]   sig,
  output logic          busy,
  output logic          done
);
  import ucs_pkg::*;
  localparam logic [AW-1:0] LAST = AW'(WORDS - 1);

  logic [AW-1:0] addr_q, addr_d;
  logic [31:0]   sig_q, sig_d;
  logic          busy_q, busy_d, done_q, done_d;

  always_comb begin
    addr_d = addr_q;
    sig_d  = sig_q;
    busy_d = busy_q;
    done_d = done_q;
    if (start) begin
      addr_d = '0;
      sig_d  = SIG_SEED;
      busy_d = 1'b1;
      done_d = 1'b0;
    end else if (busy_q) begin
      sig_d  = sig_fold(sig_q, word);
      addr_d = addr_q + 1'b1;
      if (addr_q == LAST) begin
        busy_d = 1'b0;
        done_d = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      sig_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      addr_q <= addr_d;
      sig_q  <= sig_d;
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign addr = addr_q;
  assign sig  = sig_q;
  assign busy = busy_q;
  assign done = done_q;

  // R8: the last fold ends the scan and raises done
  p_scan_end_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && !start && addr_q == LAST) |=> (done_q && !busy_q));
  // R8: busy and done never together
  p_busy_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_q && done_q));
endmodule

// File: rtl/ucs_ctrl.sv
module ucs_ctrl #(
  parameter int          AW       = 11,
  parameter int          HAW      = 22,
  parameter logic [15:0] BASE_REQ = 16'hFFA0,
  localparam int         TAGW     = HAW - AW,
  localparam int         BLSB     = 16 - TAGW
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           req,
  input  logic           regsel,
  input  logic           we,
  input  logic           fetch,
  input  logic [HAW-1:0] addr,
  input  logic [15:0]    wdata,
  input  logic           emu_a,
  input  logic           emu_b,
  input  logic [31:0]    sig_val,
  input  logic           sig_busy,
  input  logic           sig_done,
  output logic           arr_we,
  output logic           arr_re,
  output logic           sig_start,
  output logic           low_power,
  output logic           ack,
  output logic           err,
  output logic           sel_arr,
  output logic [31:0]    reg_rdata
);
  import ucs_pkg::*;

  logic        stop_q, stop_d;
  logic [15:0] base_q, base_d;
  logic        ack_q, ack_d, err_q, err_d, sel_q, sel_d;
  logic [31:0] rd_q, rd_d;
  logic        emu_any, decode, arr_ok, reg_ok;

  always_comb begin
    emu_any   = emu_a | emu_b;
    low_power = stop_q & ~emu_any;
    decode    = (base_q == BASE_REQ) && (addr[HAW-1:AW] == base_q[15:BLSB]);
    arr_ok    = req & ~regsel & ~fetch & decode & ~emu_any & ~low_power;
    reg_ok    = req & regsel & ~fetch;
    arr_we    = arr_ok & we;
    arr_re    = arr_ok & ~we;
    sig_start = reg_ok & we & (addr[1:0] == REG_STAT) & wdata[0];

    stop_d = stop_q;
    base_d = base_q;
    if (reg_ok && we) begin
      if (addr[1:0] == REG_CTRL) stop_d = wdata[0];
      if (addr[1:0] == REG_BASE) base_d = wdata;
    end

    rd_d = '0;
    if (reg_ok && !we) begin
      case (addr[1:0])
        REG_CTRL: rd_d = {30'h0, low_power, stop_q};
        REG_BASE: rd_d = {16'h0, base_q};
        REG_SIG:  rd_d = sig_val;
        default:  rd_d = {30'h0, sig_busy, sig_done};
      endcase
    end

    ack_d = arr_ok | reg_ok;
    err_d = req & ~(arr_ok | reg_ok);
    sel_d = arr_re;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_q <= 1'b0;
      base_q <= '0;
      ack_q  <= 1'b0;
      err_q  <= 1'b0;
      sel_q  <= 1'b0;
      rd_q   <= '0;
    end else begin
      stop_q <= stop_d;
      base_q <= base_d;
      ack_q  <= ack_d;
      err_q  <= err_d;
      sel_q  <= sel_d;
      rd_q   <= rd_d;
    end
  end

  assign ack       = ack_q;
  assign err       = err_q;
  assign sel_arr   = sel_q;
  assign reg_rdata = rd_q;

  // R3: array access during emulation is rejected
  p_lockout_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !regsel && (emu_a || emu_b)) |=> (err && !ack));
  // R5: array access in low-power state is rejected
  p_stopped_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req && !regsel && low_power) |=> err);
  // R7: instruction fetches are rejected
  p_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (req && fetch) |=> (err && !ack));
  // R1: a response is either accept or reject
  p_resp_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(ack && err));
endmodule

// File: rtl/ucs_ram.sv
module ucs_ram #(
  parameter int          WORDS    = 2048,
  parameter int          HAW      = 22,
  parameter logic [15:0] BASE_REQ = 16'hFFA0,
  localparam int         AW       = $clog2(WORDS)
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           hst_req,
  input  logic           hst_reg,
  input  logic           hst_we,
  input  logic           hst_fetch,
  input  logic [HAW-1:0] hst_addr,
  input  logic [31:0]    hst_wdata,
  output logic           hst_ack,
  output logic           hst_err,
  output logic [31:0]    hst_rdata,
  input  logic           emu_a,
  input  logic           emu_b,
  input  logic           eng_a_rd,
  input  logic [AW-1:0]  eng_a_addr,
  output logic [31:0]    eng_a_rdata,
  input  logic           eng_b_rd,
  input  logic [AW-1:0]  eng_b_addr,
  output logic [31:0]    eng_b_rdata,
  output logic           low_power
);
  logic          arr_we, arr_re, sig_start, sel_arr, sig_busy, sig_done;
  logic [31:0]   reg_rdata, arr_rdata, sig_val, sig_word;
  logic [AW-1:0] sig_addr;
  logic [AW-1:0] e_addr  [2];
  logic [31:0]   e_rdata [2];

  assign e_addr[0]   = eng_a_addr;
  assign e_addr[1]   = eng_b_addr;
  assign eng_a_rdata = e_rdata[0];
  assign eng_b_rdata = e_rdata[1];

  ucs_ctrl #(.AW(AW), .HAW(HAW), .BASE_REQ(BASE_REQ)) i_ctrl (
    .clk, .rst_n, .req(hst_req), .regsel(hst_reg), .we(hst_we), .fetch(hst_fetch),
    .addr(hst_addr), .wdata(hst_wdata[15:0]), .emu_a, .emu_b,
    .sig_val, .sig_busy, .sig_done, .arr_we, .arr_re, .sig_start, .low_power,
    .ack(hst_ack), .err(hst_err), .sel_arr, .reg_rdata);

  ucs_array #(.WORDS(WORDS), .DW(32)) i_array (
    .clk, .rst_n, .h_we(arr_we), .h_re(arr_re), .h_addr(hst_addr[AW-1:0]),
    .h_wdata(hst_wdata), .h_rdata(arr_rdata),
    .e_rd({eng_b_rd, eng_a_rd}), .e_en({emu_b, emu_a}), .e_addr, .e_rdata,
    .s_addr(sig_addr), .s_word(sig_word));

  ucs_sig #(.WORDS(WORDS)) i_sig (
    .clk, .rst_n, .start(sig_start), .word(sig_word), .addr(sig_addr),
    .sig(sig_val), .busy(sig_busy), .done(sig_done));

  assign hst_rdata = sel_arr ? arr_rdata : reg_rdata;
endmodule

// File: tb/test_ucs_ram.sv
module test_ucs_ram;
  localparam int WORDS = 2048;
  localparam logic [10:0] TAG = 11'h7FD;

  logic clk, rst_n;
  logic hst_req, hst_reg, hst_we, hst_fetch;
  logic [21:0] hst_addr;
  logic [31:0] hst_wdata, hst_rdata;
  logic hst_ack, hst_err, emu_a, emu_b, eng_a_rd, eng_b_rd, low_power;
  logic [10:0] eng_a_addr, eng_b_addr;
  logic [31:0] eng_a_rdata, eng_b_rdata;

  int total = 0, bad = 0;
  logic [31:0] model [WORDS];

  ucs_ram i_ucs_ram (.*);

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hop(input logic rs, input logic we, input logic fe, input logic [21:0] a,
                     input logic [31:0] wd, output logic ack, output logic err, output logic [31:0] rd);
    @(negedge clk);
    hst_req = 1'b1; hst_reg = rs; hst_we = we; hst_fetch = fe; hst_addr = a; hst_wdata = wd;
    @(negedge clk);
    ack = hst_ack; err = hst_err; rd = hst_rdata;
    hst_req = 1'b0; hst_we = 1'b0; hst_fetch = 1'b0;
  endtask

  function automatic logic [21:0] aaddr(input logic [10:0] w);
    return {TAG, w};
  endfunction

  function automatic logic [31:0] exp_sig();
    logic [31:0] s = 32'hFFFFFFFF;
    for (int i = 0; i < WORDS; i++)
      s = ({s[30:0], 1'b0} ^ (s[31] ? 32'h04C11DB7 : 32'h0)) ^ model[i];
    return s;
  endfunction

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=%h expected=%h", 0, 1);
    finish_run();
  end

  initial begin
    logic ack, err; logic [31:0] rd;
    int fails; logic [10:0] w, x; logic [31:0] d;
    void'($urandom(32'd2024));
    rst_n = 1'b0; hst_req = 0; hst_reg = 0; hst_we = 0; hst_fetch = 0; hst_addr = 0; hst_wdata = 0;
    emu_a = 0; emu_b = 0; eng_a_rd = 0; eng_b_rd = 0; eng_a_addr = 0; eng_b_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!hst_ack && !hst_err && !low_power, "R9 reset outputs", {hst_ack, hst_err, low_power}, 0);
    hop(1, 0, 0, 22'd0, 0, ack, err, rd); chk(ack && rd == 0, "R9 ctrl reset", rd, 0);
    hop(1, 0, 0, 22'd1, 0, ack, err, rd); chk(ack && rd == 0, "R9 base reset", rd, 0);
    hop(1, 0, 0, 22'd3, 0, ack, err, rd); chk(ack && rd == 0, "R9 status reset", rd, 0);

    // R2: base not programmed
    hop(0, 1, 0, aaddr(11'd5), 32'h1234, ack, err, rd);
    chk(err && !ack, "R2 unprogrammed base", {ack, err}, 1);
    hop(1, 1, 0, 22'd1, 32'h0000FFA0, ack, err, rd);
    hop(1, 0, 0, 22'd1, 0, ack, err, rd); chk(rd == 32'hFFA0, "R9 base readback", rd, 32'hFFA0);

    // R1: fill every word
    fails = 0;
    for (int i = 0; i < WORDS; i++) begin
      d = $urandom; model[i] = d;
      hop(0, 1, 0, aaddr(11'(i)), d, ack, err, rd);
      if (!ack || err) fails++;
    end
    chk(fails == 0, "R1 fill acked", fails, 0);

    // R1/R2: random mix
    for (int i = 0; i < 400; i++) begin
      int k; k = $urandom % 8; w = 11'($urandom);
      if (k < 3) begin
        d = $urandom; model[w] = d;
        hop(0, 1, 0, aaddr(w), d, ack, err, rd);
        chk(ack && !err, "R1 write ack", {ack, err}, 2);
      end else if (k < 7) begin
        hop(0, 0, 0, aaddr(w), 0, ack, err, rd);
        chk(ack && rd == model[w], "R1 read data", rd, model[w]);
      end else begin
        logic [10:0] t; t = 11'($urandom); if (t == TAG) t = 11'h123;
        hop(0, k[0], 0, {t, w}, $urandom, ack, err, rd);
        chk(err && !ack && rd == 0, "R2 outside region", rd, 0);
      end
    end
    hop(0, 0, 0, aaddr(11'd0), 0, ack, err, rd);
    chk(rd == model[0], "R2 no stray write", rd, model[0]);

    // R7: fetches
    hop(0, 0, 1, aaddr(11'd9), 0, ack, err, rd);
    chk(err && !ack, "R7 fetch read rejected", {ack, err}, 1);
    hop(0, 1, 1, aaddr(11'd9), 32'hDEADBEEF, ack, err, rd);
    chk(err, "R7 fetch write rejected", {ack, err}, 1);
    hop(1, 0, 1, 22'd1, 0, ack, err, rd);
    chk(err, "R7 register fetch rejected", {ack, err}, 1);
    hop(0, 0, 0, aaddr(11'd9), 0, ack, err, rd);
    chk(rd == model[9], "R7 array unchanged", rd, model[9]);

    // R3/R4: engine A only
    emu_a = 1;
    hop(0, 1, 0, aaddr(11'd20), 32'hCAFEF00D, ack, err, rd);
    chk(err && !ack, "R3 write locked out", {ack, err}, 1);
    @(negedge clk);
    eng_a_rd = 1; eng_a_addr = 11'd20; eng_b_rd = 1; eng_b_addr = 11'd21;
    @(negedge clk);
    eng_a_rd = 0; eng_b_rd = 0;
    chk(eng_a_rdata == model[20], "R4 engine A read", eng_a_rdata, model[20]);
    chk(eng_b_rdata == 0, "R4 idle engine B reads zero", eng_b_rdata, 0);

    // R3/R4: both engines plus host attempt in the same cycle
    emu_b = 1;
    fails = 0;
    for (int i = 0; i < 64; i++) begin
      logic hw; logic [10:0] hx;
      w = 11'($urandom); x = (i == 0) ? w : 11'($urandom); hx = 11'($urandom); hw = 1'($urandom);
      @(negedge clk);
      eng_a_rd = 1; eng_a_addr = w; eng_b_rd = 1; eng_b_addr = x;
      hst_req = 1; hst_reg = 0; hst_we = hw; hst_addr = aaddr(hx); hst_wdata = ~model[hx];
      @(negedge clk);
      eng_a_rd = 0; eng_b_rd = 0; hst_req = 0; hst_we = 0;
      if (eng_a_rdata != model[w] || eng_b_rdata != model[x] || !hst_err || hst_ack) begin
        fails++;
        $display("FAIL R4 dual read a=%h/%h b=%h/%h err=%b", eng_a_rdata, model[w], eng_b_rdata, model[x], hst_err);
      end
    end
    chk(fails == 0, "R4 dual read with host attempt", fails, 0);

    // R6: STOP held off by emulation
    hop(1, 1, 0, 22'd0, 32'h1, ack, err, rd);
    chk(ack && !low_power, "R6 stop suppressed by emulation", low_power, 0);
    emu_a = 0;
    @(negedge clk);
    chk(!low_power, "R6 one engine still emulating", low_power, 0);
    emu_b = 0;
    @(negedge clk);
    chk(low_power, "R6 low power after emulation ends", low_power, 1);

    // R3: discarded write check
    hop(0, 0, 0, aaddr(11'd20), 0, ack, err, rd);
    chk(err, "R5 array rejected while stopped", {ack, err}, 1);
    hop(1, 0, 0, 22'd0, 0, ack, err, rd);
    chk(ack && rd == 32'h3, "R5 register access while stopped", rd, 32'h3);
    hop(1, 1, 0, 22'd0, 32'h0, ack, err, rd);
    chk(!low_power, "R5 stop cleared", low_power, 0);
    hop(0, 0, 0, aaddr(11'd20), 0, ack, err, rd);
    chk(ack && rd == model[20], "R3 locked write discarded", rd, model[20]);

    // R5: stop without emulation
    hop(1, 1, 0, 22'd0, 32'h1, ack, err, rd);
    chk(low_power, "R5 low power entered", low_power, 1);
    hop(0, 1, 0, aaddr(11'd30), 32'h55AA55AA, ack, err, rd);
    chk(err && !ack, "R5 write rejected while stopped", {ack, err}, 1);
    hop(1, 1, 0, 22'd0, 32'h0, ack, err, rd);

    // R8: signature
    hop(1, 1, 0, 22'd3, 32'h1, ack, err, rd);
    hop(1, 0, 0, 22'd3, 0, ack, err, rd);
    chk(rd == 32'h2, "R8 busy after start", rd, 2);
    fails = 0;
    while (rd != 32'h1 && fails < 3000) begin
      hop(1, 0, 0, 22'd3, 0, ack, err, rd);
      fails++;
    end
    chk(rd == 32'h1, "R8 done raised", rd, 1);
    chk(fails >= (WORDS - 2) / 2 - 2, "R8 scan length", fails, (WORDS - 2) / 2);
    hop(1, 0, 0, 22'd2, 0, ack, err, rd);
    d = exp_sig();
    chk(rd == d, "R8 signature value", rd, d);

    finish_run();
  end
endmodule